// File: doc/BRIEF.md
# Pipelined burst SRAM

This block is a synthesizable single-clock static RAM with a pipelined read path, an internal two-bit burst sequencer and byte-lane write control. All inputs are captured on the rising clock edge. Each cycle is one of four kinds: a burst start at the presented address, a burst continuation at an internally generated address, a deselect, or idle.

Either of two strobes starts a burst: one meant for a processor and one meant for a cache controller. Within the burst, an advance input steps a two-bit counter. A mode input chooses linear or interleaved order. The data bus is split into a write-data input, a read-data output and a drive-enable output. Drive-enable marks the cycles in which a bidirectional pad would drive read data.

A write either covers every lane (global write) or covers only the selected lanes (byte-write enable plus one bit per lane). Each lane is 9 bits: 8 data bits and 1 parity bit.

Top module: `pburst_sram`

## Requirements
- R1: A read presented in cycle n drives `rd_oe_o` high and `rd_data_o` with the stored word after the edge that ends cycle n+1. Consecutive reads give one word per clock. A write cycle or an idle cycle leaves `rd_oe_o` low two edges later.
- R2: Either strobe starts a burst when all three selects are high: `start_ctl_i` alone, or `start_cpu_i` with `sel_pri_i` high. The first access of the burst uses `addr_i`, and the step counter restarts at 0.
- R3: In a burst cycle with no strobe and `adv_i` low, the access repeats the previous address.
- R4: With `order_ilv_i` low, each advance adds 1 modulo 4 to address bits [1:0] and leaves the upper address bits unchanged. For example, a burst from 0x010 visits 0x011, 0x012 and 0x013, then returns to 0x010.
- R5: With `order_ilv_i` high, address bits [1:0] equal the start's bits [1:0] XOR the step count. A start at 0x011 gives 0x010, 0x013, 0x012.
- R6: When `wr_all_i` is high in an access cycle, all lanes take `wr_data_i`, whatever the values of `wr_byte_en_i` and `lane_we_i`.
- R7: When `wr_all_i` is low, a write takes place only if `wr_byte_en_i` is high. It then updates only lane k (bits 9k+8..9k) for each set `lane_we_i[k]`. With both enables low, the cycle is a read.
- R8: A strobe (`start_ctl_i`, or `start_cpu_i` with `sel_pri_i` high) while any select is low ends the burst. `rd_oe_o` is low two edges later. Later cycles without a strobe make no access, even with `adv_i` high.
- R9: `start_cpu_i` is ignored while `sel_pri_i` is low. The current burst continues unchanged.
- R10: A strobe that starts a burst while another burst is active reloads the start address and clears the step count.
- R11: Synchronous reset ends any burst and clears `rd_oe_o`. After reset, `adv_i` alone starts no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr_i | input | ADDR_W | Word address used when a strobe starts a burst |
| start_cpu_i | input | 1 | Processor-side burst strobe, qualified by `sel_pri_i` |
| start_ctl_i | input | 1 | Cache-controller-side burst strobe |
| adv_i | input | 1 | Step the burst counter in this cycle |
| sel_pri_i | input | 1 | Primary select, active high |
| sel_b_i | input | 1 | Second select, active high |
| sel_c_i | input | 1 | Third select, active high |
| order_ilv_i | input | 1 | 0 = linear burst order, 1 = interleaved |
| wr_all_i | input | 1 | Global write of all lanes |
| wr_byte_en_i | input | 1 | Enable for per-lane writes |
| lane_we_i | input | LANES | Per-lane write selects |
| wr_data_i | input | LANES*LANE_W | Write data, same cycle as the access |
| rd_data_o | output | LANES*LANE_W | Registered read data |
| rd_oe_o | output | 1 | High when read data would be driven |

## Verification
Read data and the drive enable are due at the second rising edge after the cycle that presents the access. A write reaches the array on the edge after its cycle is captured, so a read presented in the following cycle returns the new word. A deselect, idle or write cycle shows up as a low drive enable two edges later. The bench applies each stimulus row just after a falling edge and samples at the next falling edge. The expected value stored in row n therefore describes the access of row n-1. Each burst, mode and lane case is written so that its result lands in a sampled row.

// File: rtl/pburst_sram_pkg.sv
package pburst_sram_pkg;

  // step count inside a four-beat burst
  typedef logic [1:0] step_t;

  // low address bits for a given step, linear or interleaved
  function automatic logic [1:0] burst_low(input logic [1:0] start, input step_t step,
                                           input logic ilv);
    return ilv ? (start ^ step) : (start + step);
  endfunction

endpackage

// File: rtl/pburst_seq.sv
module pburst_seq
  import pburst_sram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              start_cpu_i,
  input  logic              start_ctl_i,
  input  logic              adv_i,
  input  logic              sel_pri_i,
  input  logic              sel_all_i,
  input  logic              order_ilv_i,
  output logic              acc_go_o,
  output logic [ADDR_W-1:0] acc_addr_o,
  output logic              burst_on_o
);

  logic              strobe, load, desel;
  logic [ADDR_W-1:0] base_q;
  step_t             step_q, step_nxt;
  logic              on_q;

  assign strobe   = (start_cpu_i & sel_pri_i) | start_ctl_i;
  assign load     = strobe & sel_all_i;
  assign desel    = strobe & ~sel_all_i;
  assign step_nxt = adv_i ? step_q + 2'd1 : step_q;

  always_comb begin
    acc_go_o   = load | (~strobe & on_q);
    acc_addr_o = load ? addr_i
                      : {base_q[ADDR_W-1:2], burst_low(base_q[1:0], step_nxt, order_ilv_i)};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      on_q   <= 1'b0;
      step_q <= '0;
      base_q <= '0;
    end else if (load) begin
      on_q   <= 1'b1;
      step_q <= '0;
      base_q <= addr_i;
    end else if (desel) begin
      on_q   <= 1'b0;
    end else if (on_q) begin
      step_q <= step_nxt;
    end
  end

  assign burst_on_o = on_q;

endmodule

// File: rtl/pburst_lane_dec.sv
module pburst_lane_dec #(
  parameter int LANES = 4
) (
  input  logic             wr_all_i,
  input  logic             wr_byte_en_i,
  input  logic [LANES-1:0] lane_we_i,
  output logic [LANES-1:0] mask_o,
  output logic             wr_req_o
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign mask_o[g] = wr_all_i | (wr_byte_en_i & lane_we_i[g]);
  end

  assign wr_req_o = |mask_o;

endmodule

// File: rtl/pburst_array.sv
module pburst_array #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES-1:0]        we_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic [LANES*LANE_W-1:0] rdata_o
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] q;

    always_ff @(posedge clk) begin
      if (we_i[g]) mem[addr_i] <= wdata_i[g*LANE_W +: LANE_W];
      q <= mem[addr_i];
    end

    assign rdata_o[g*LANE_W +: LANE_W] = q;
  end

endmodule

// File: rtl/pburst_sram.sv
module pburst_sram #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    start_cpu_i,
  input  logic                    start_ctl_i,
  input  logic                    adv_i,
  input  logic                    sel_pri_i,
  input  logic                    sel_b_i,
  input  logic                    sel_c_i,
  input  logic                    order_ilv_i,
  input  logic                    wr_all_i,
  input  logic                    wr_byte_en_i,
  input  logic [LANES-1:0]        lane_we_i,
  input  logic [LANES*LANE_W-1:0] wr_data_i,
  output logic [LANES*LANE_W-1:0] rd_data_o,
  output logic                    rd_oe_o
);

  localparam int DATA_W = LANES * LANE_W;

  logic              sel_all;
  logic              acc_go, burst_on, wr_req;
  logic [ADDR_W-1:0] acc_addr, addr_q;
  logic [LANES-1:0]  lane_mask, wr_mask_q;
  logic [DATA_W-1:0] wdata_q;
  logic              rd_q;

  assign sel_all = sel_pri_i & sel_b_i & sel_c_i;

  pburst_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .addr_i     (addr_i),
    .start_cpu_i(start_cpu_i),
    .start_ctl_i(start_ctl_i),
    .adv_i      (adv_i),
    .sel_pri_i  (sel_pri_i),
    .sel_all_i  (sel_all),
    .order_ilv_i(order_ilv_i),
    .acc_go_o   (acc_go),
    .acc_addr_o (acc_addr),
    .burst_on_o (burst_on)
  );

  pburst_lane_dec #(.LANES(LANES)) u_dec (
    .wr_all_i    (wr_all_i),
    .wr_byte_en_i(wr_byte_en_i),
    .lane_we_i   (lane_we_i),
    .mask_o      (lane_mask),
    .wr_req_o    (wr_req)
  );

  // control stage: reset-cleared
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q      <= 1'b0;
      wr_mask_q <= '0;
      rd_oe_o   <= 1'b0;
    end else begin
      rd_q      <= acc_go & ~wr_req;
      wr_mask_q <= acc_go ? lane_mask : '0;
      rd_oe_o   <= rd_q;
    end
  end

  // data stage: no reset, keeps RAM inference clean
  always_ff @(posedge clk) begin
    if (acc_go) addr_q <= acc_addr;
    wdata_q <= wr_data_i;
  end

  pburst_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk    (clk),
    .addr_i (addr_q),
    .we_i   (wr_mask_q),
    .wdata_i(wdata_q),
    .rdata_o(rd_data_o)
  );

endmodule

// File: rtl/pburst_sram_chk.sv
module pburst_sram_chk #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr_i,
  input logic              start_cpu_i,
  input logic              start_ctl_i,
  input logic              adv_i,
  input logic              sel_pri_i,
  input logic              sel_b_i,
  input logic              sel_c_i,
  input logic              order_ilv_i,
  input logic              wr_all_i,
  input logic              wr_byte_en_i,
  input logic [LANES-1:0]  lane_we_i,
  input logic              rd_oe_o,
  input logic              burst_on,
  input logic [ADDR_W-1:0] addr_q,
  input logic [LANES-1:0]  wr_mask_q
);

  logic all_sel, any_strobe, write_ask;
  assign all_sel    = sel_pri_i & sel_b_i & sel_c_i;
  assign any_strobe = (start_cpu_i & sel_pri_i) | start_ctl_i;
  assign write_ask  = wr_all_i | (wr_byte_en_i & (|lane_we_i));

  AST_READ_DRIVES: assert property (@(posedge clk) disable iff (rst)
    (start_ctl_i && all_sel && !write_ask) |-> ##2 rd_oe_o); // R1

  AST_CTL_LOADS: assert property (@(posedge clk) disable iff (rst)
    (start_ctl_i && all_sel) |=> (addr_q == $past(addr_i))); // R2

  AST_HOLD_NO_ADV: assert property (@(posedge clk) disable iff (rst)
    (burst_on && !any_strobe && !adv_i) |=> $stable(addr_q)); // R3

  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (rst)
    (burst_on && !any_strobe && adv_i && !order_ilv_i) |=>
      (addr_q[1:0] == $past(addr_q[1:0]) + 2'd1) &&
      (addr_q[ADDR_W-1:2] == $past(addr_q[ADDR_W-1:2]))); // R4

  AST_ILV_STEP: assert property (@(posedge clk) disable iff (rst)
    (burst_on && !any_strobe && adv_i && order_ilv_i) |=>
      (addr_q[1:0] != $past(addr_q[1:0]))); // R5

  AST_GLOBAL_ALL_LANES: assert property (@(posedge clk) disable iff (rst)
    (start_ctl_i && all_sel && wr_all_i) |=> (wr_mask_q == {LANES{1'b1}})); // R6

  AST_NO_ENABLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!wr_all_i && !wr_byte_en_i) |=> (wr_mask_q == '0)); // R7

  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (rst)
    (start_ctl_i && !all_sel) |-> ##2 !rd_oe_o); // R8

  AST_CPU_GATED: assert property (@(posedge clk) disable iff (rst)
    (start_cpu_i && !sel_pri_i && !start_ctl_i) |=> $stable(burst_on)); // R9

  AST_CPU_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (start_cpu_i && all_sel && !start_ctl_i) |=> (addr_q == $past(addr_i))); // R10

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!rd_oe_o && !burst_on)); // R11

endmodule

bind pburst_sram pburst_sram_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .addr_i      (addr_i),
  .start_cpu_i (start_cpu_i),
  .start_ctl_i (start_ctl_i),
  .adv_i       (adv_i),
  .sel_pri_i   (sel_pri_i),
  .sel_b_i     (sel_b_i),
  .sel_c_i     (sel_c_i),
  .order_ilv_i (order_ilv_i),
  .wr_all_i    (wr_all_i),
  .wr_byte_en_i(wr_byte_en_i),
  .lane_we_i   (lane_we_i),
  .rd_oe_o     (rd_oe_o),
  .burst_on    (burst_on),
  .addr_q      (addr_q),
  .wr_mask_q   (wr_mask_q)
);

// File: tb/pburst_sram_test.sv
`timescale 1ns/1ps
module pburst_sram_test;

  localparam int AW = 10;
  localparam int NL = 4;
  localparam int LW = 9;
  localparam int DW = NL * LW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic          start_cpu_i = 1'b0, start_ctl_i = 1'b0, adv_i = 1'b0;
  logic          sel_pri_i = 1'b1, sel_b_i = 1'b1, sel_c_i = 1'b1;
  logic          order_ilv_i = 1'b0, wr_all_i = 1'b0, wr_byte_en_i = 1'b0;
  logic [NL-1:0] lane_we_i = '0;
  logic [DW-1:0] wr_data_i = '0;
  logic [DW-1:0] rd_data_o;
  logic          rd_oe_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  pburst_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) uut (
    .clk(clk), .rst(rst), .addr_i(addr_i),
    .start_cpu_i(start_cpu_i), .start_ctl_i(start_ctl_i), .adv_i(adv_i),
    .sel_pri_i(sel_pri_i), .sel_b_i(sel_b_i), .sel_c_i(sel_c_i),
    .order_ilv_i(order_ilv_i), .wr_all_i(wr_all_i), .wr_byte_en_i(wr_byte_en_i),
    .lane_we_i(lane_we_i), .wr_data_i(wr_data_i),
    .rd_data_o(rd_data_o), .rd_oe_o(rd_oe_o)
  );

  typedef struct packed {
    logic          sc, sp, adv, s0, s1, s2, ilv, gw, bwe;
    logic [3:0]    ln;
    logic [9:0]    a;
    logic [35:0]   d;
    logic          eoe;  // expected drive after this row's edge (reflects previous row)
    logic [35:0]   ed;
    logic [3:0]    req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    // linear write burst from 0x010 (global write)
    '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,4'h0,10'h010,36'h100000010,1'b0,36'h0,4'd11},
    '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,4'h0,10'h000,36'h100000011,1'b0,36'h0,4'd1},
    '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,4'h0,10'h000,36'h100000012,1'b0,36'h0,4'd6},
    '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,4'h0,10'h000,36'h100000013,1'b0,36'h0,4'd6},
    // wrap to 0x010, read
    '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,4'h0,10'h000,36'h0,1'b0,36'h0,4'd4},
    // processor strobe reloads mid-burst at 0x011, interleaved reads
    '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,4'h0,10'h011,36'h0,1'b1,36'h100000010,4'd4},
    '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,4'h0,10'h000,36'h0,1'b1,36'h100000011,4'd2},
    '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,4'h0,10'h000,36'h0,1'b1,36'h100000010,4'd5},
    '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,4'h0,10'h000,36'h0,1'b1,36'h100000013,4'd5},
    // hold (no advance)
    '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,4'h0,10'h000,36'h0,1'b1,36'h100000012,4'd5},
    // deselect via second select low
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,4'h0,10'h000,36'h0,1'b1,36'h100000012,4'd3},
    '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,4'h0,10'h000,36'h0,1'b0,36'h0,4'd8},
    // byte write lanes 0 and 2 at 0x011
    '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b1,4'h5,10'h011,36'hFFFFFFFFF,1'b0,36'h0,4'd8},
    // lane bits without byte-write enable: read at 0x012
    '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,4'hF,10'h000,36'h0,1'b0,36'h0,4'd7},
    '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,4'h0,10'h011,36'h0,1'b1,36'h100000012,4'd7},
    '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,4'h0,10'h012,36'h0,1'b1,36'h107FC01FF,4'd10},
    // global write with no lane bits at 0x013
    '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,4'h0,10'h013,36'h022222222,1'b1,36'h100000012,4'd7},
    '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,4'h0,10'h013,36'h0,1'b0,36'h0,4'd6},
    // processor strobe with primary select low: ignored
    '{1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,4'h0,10'h000,36'h0,1'b1,36'h022222222,4'd6},
    '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,4'h0,10'h000,36'h0,1'b1,36'h022222222,4'd9},
    '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,4'h0,10'h000,36'h0,1'b1,36'h022222222,4'd9},
    '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,4'h0,10'h000,36'h0,1'b0,36'h0,4'd8}
  };

  function automatic string req_name(input logic [3:0] r);
    case (r)
      4'd1:  return "R1";
      4'd2:  return "R2";
      4'd3:  return "R3";
      4'd4:  return "R4";
      4'd5:  return "R5";
      4'd6:  return "R6";
      4'd7:  return "R7";
      4'd8:  return "R8";
      4'd9:  return "R9";
      4'd10: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic idle_inputs();
    start_cpu_i = 1'b0; start_ctl_i = 1'b0; adv_i = 1'b0;
    sel_pri_i = 1'b1; sel_b_i = 1'b1; sel_c_i = 1'b1;
    order_ilv_i = 1'b0; wr_all_i = 1'b0; wr_byte_en_i = 1'b0;
    lane_we_i = '0; addr_i = '0; wr_data_i = '0;
  endtask

  task automatic drive(input vec_t v);
    start_ctl_i = v.sc; start_cpu_i = v.sp; adv_i = v.adv;
    sel_pri_i = v.s0; sel_b_i = v.s1; sel_c_i = v.s2;
    order_ilv_i = v.ilv; wr_all_i = v.gw; wr_byte_en_i = v.bwe;
    lane_we_i = v.ln; addr_i = v.a; wr_data_i = v.d;
  endtask

  task automatic check_out(input logic eoe, input logic [DW-1:0] ed, input string tag);
    n_run++;
    if (rd_oe_o !== eoe || (eoe && rd_data_o !== ed)) begin
      n_fail++;
      $display("FAIL %s: oe=%0b data=%h expected oe=%0b data=%h", tag, rd_oe_o, rd_data_o, eoe, ed);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_out(1'b0, '0, "R11 reset state");
    rst = 1'b0;

    // table walk: row i's expectation reflects row i-1's access
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      step();
      check_out(VEC[i].eoe, VEC[i].ed, $sformatf("%s row %0d", req_name(VEC[i].req), i));
    end

    // R11: reset in the middle of a read burst
    idle_inputs();
    start_ctl_i = 1'b1; addr_i = 10'h010;
    step();
    idle_inputs();
    rst = 1'b1;
    step();
    check_out(1'b0, '0, "R11 reset mid-burst");
    rst = 1'b0;
    // R11: advance alone after reset makes no access
    adv_i = 1'b1;
    for (int k = 0; k < 3; k++) begin
      step();
      check_out(1'b0, '0, "R11 advance after reset");
    end
    idle_inputs();

    // R1: back-to-back controller reads, one word per clock
    start_ctl_i = 1'b1; addr_i = 10'h012;
    step();
    addr_i = 10'h013;
    step();
    idle_inputs();
    check_out(1'b1, 36'h100000012, "R1 first of pair");
    step();
    check_out(1'b1, 36'h022222222, "R1 second of pair");

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL R1 watchdog: run not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule